// File: doc/BRIEF.md
# Read-Request Responder with Streaming Packetizer

This block serves read requests. A decoded request header arrives as one 104-bit word, together with a valid/ready handshake. The block checks that the word is a read request and decodes the requested length from the size code and word pointer. It then reads the payload, one 16-byte word at a time, from a synchronous local memory port that returns data one cycle after the read.

The block sends the response as a single packet on a 128-bit ready/valid stream. The first beat carries an 8-byte response header in its upper half and the first 8 payload bytes in its lower half. Each later beat carries the remaining bytes in order. The total packet size is shown with the first beat. The number of unused trailing bytes is shown with the last beat.

A header that fails the checks is dropped. It produces a one-cycle error strobe and no response. Only one response is in flight at a time.

Top module: `rdResponder`

## Requirements
- R1: A beat transfers only in a cycle where txValid and txReady are both high. Once the first beat of a packet is shown, txValid stays high with txData, txSop, txEop, txEmpty and txSize unchanged while stalled, until the last beat has transferred.
- R2: txSop is high only on the first beat of a packet and txEop only on the last. Beats between them drive both low.
- R3: txSize, shown on every beat of a packet, equals 8 plus the payload length: 40 for a 32-byte payload and 72 for a 64-byte one.
- R4: txEmpty is 8 on the last beat and 0 on every other beat. A 40-byte packet takes 3 beats and a 72-byte packet takes 5.
- R5: A request is valid only when all three hold: format type reqHdr[99:96] is 2, transaction type reqHdr[63:60] is 4, and the reserved bits reqHdr[15:0] are zero.
- R6: Size code reqHdr[59:56] = 4'b1100 selects the length from the word pointer reqHdr[18]: 32 bytes when it is 0, 64 bytes when it is 1. Any other size code is invalid.
- R7: An invalid request is accepted and dropped. reqErr goes high for exactly one cycle, the cycle after acceptance, and no beat is emitted for it.
- R8: The response header fills the first beat's txData[127:64], from the most significant bit down. It holds: priority (request reqHdr[103:102] plus one, saturating at 3), 2 bits; transport type copied from reqHdr[101:100], 2 bits; format type 13, 4 bits; target ID = request source ID reqHdr[79:64], 16 bits; responder ID = request destination ID reqHdr[95:80], 16 bits; transaction type 8, 4 bits; status 0, 4 bits; tag copied from reqHdr[55:48], 8 bits; 8 zero bits.
- R9: The payload is read from consecutive memory words. The first word index is the low AW bits of {reqHdr[17:16], reqHdr[47:19]} shifted right by one, and the index wraps modulo 2^AW. Each word's bytes are sent most significant byte first, straight after the header. Unused bytes of the last beat are zero.
- R10: reqReady is low from the cycle after a valid request is accepted until the cycle after its last beat transfers, and high otherwise. A request held on reqValid during a response is not taken until then.
- R11: After reset, txValid and reqErr are low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request header present |
| reqReady | output | 1 | Block can take a request |
| reqHdr | input | 104 | Decoded request header word |
| reqErr | output | 1 | One-cycle strobe for a dropped request |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | AW | Memory word index |
| memRdData | input | 128 | Memory word, valid the cycle after the read |
| txValid | output | 1 | Stream beat valid |
| txReady | input | 1 | Stream sink can take a beat |
| txData | output | 128 | Beat data, byte 0 in bits [127:120] |
| txSop | output | 1 | First beat of the packet |
| txEop | output | 1 | Last beat of the packet |
| txEmpty | output | 4 | Unused trailing bytes on the last beat |
| txSize | output | 8 | Total packet bytes |

## Verification
Two events can fall in the same cycle: a stream stall (txReady low) and the return of a prefetched memory word. In that case the word must be held back, and the next beat must be built from the held copy instead of from the memory port. The bench provokes this overlap by driving txReady with random gaps across many 32-byte and 64-byte packets at varied addresses. It also keeps a request waiting on reqValid during each response. Each emitted beat is compared against a byte stream rebuilt in the bench from the header fields and the memory contents. The stream is checked on every clock, so a lost or repeated word, or a bubble in txValid, shows up at once.

// File: rtl/rdrsp_pkg.sv
package rdrsp_pkg;
  localparam int HDR_W = 104;
  localparam int BUS_W = 128;
  localparam int HALF_W = BUS_W / 2;
  localparam int CNT_W = 3;
  localparam logic [3:0] REQ_FTYPE = 4'd2;
  localparam logic [3:0] REQ_TTYPE = 4'd4;
  localparam logic [3:0] RSP_FTYPE = 4'd13;
  localparam logic [3:0] RSP_TTYPE = 4'd8;
  localparam logic [3:0] SIZE_CODE = 4'b1100;
  localparam logic [3:0] TAIL_EMPTY = 4'd8;
  localparam logic [7:0] RSP_HDR_BYTES = 8'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHdr;
    logic loadFirst;
    logic capNext;
    logic advance;
    logic padTail;
    logic useMem;
  } dpCtrl_t;
endpackage

// File: rtl/rdrsp_datapath.sv
module rdrsp_datapath
  import rdrsp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [HDR_W-1:0]    reqHdr,
  input  logic [BUS_W-1:0]    memRdData,
  input  dpCtrl_t             ctrl,
  output logic                hdrOk,
  output logic [CNT_W-1:0]    decWords,
  output logic [AW-1:0]       reqBase,
  output logic [AW-1:0]       baseWord,
  output logic [BUS_W-1:0]    txData
);
  logic [30:0]       extDwAddr;
  logic [30:0]       extWordAddr;
  logic [1:0]        prioInc;
  logic [HALF_W-1:0] rspHdrQ;
  logic [HALF_W-1:0] lowHalfQ;
  logic [BUS_W-1:0]  nextWordQ;
  logic [BUS_W-1:0]  srcWord;
  logic [BUS_W-1:0]  txDataQ;
  logic [AW-1:0]     baseWordQ;

  always_comb begin
    hdrOk = (reqHdr[99:96] == REQ_FTYPE) && (reqHdr[63:60] == REQ_TTYPE) &&
            (reqHdr[59:56] == SIZE_CODE) && (reqHdr[15:0] == 16'h0000);
    decWords = reqHdr[18] ? CNT_W'(4) : CNT_W'(2);
    extDwAddr = {reqHdr[17:16], reqHdr[47:19]};
    extWordAddr = extDwAddr >> 1;
    reqBase = AW'(extWordAddr);
    prioInc = (reqHdr[103:102] == 2'd3) ? 2'd3 : reqHdr[103:102] + 2'd1;
    srcWord = ctrl.useMem ? memRdData : nextWordQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHdrQ   <= '0;
      lowHalfQ  <= '0;
      nextWordQ <= '0;
      txDataQ   <= '0;
      baseWordQ <= '0;
    end else begin
      if (ctrl.loadHdr) begin
        rspHdrQ <= {prioInc, reqHdr[101:100], RSP_FTYPE, reqHdr[79:64],
                    reqHdr[95:80], RSP_TTYPE, 4'h0, reqHdr[55:48], 8'h00};
        baseWordQ <= reqBase;
      end
      if (ctrl.loadFirst) begin
        txDataQ  <= {rspHdrQ, memRdData[BUS_W-1:HALF_W]};
        lowHalfQ <= memRdData[HALF_W-1:0];
      end
      if (ctrl.capNext) nextWordQ <= memRdData;
      if (ctrl.advance) begin
        if (ctrl.padTail) begin
          txDataQ <= {lowHalfQ, {HALF_W{1'b0}}};
        end else begin
          txDataQ  <= {lowHalfQ, srcWord[BUS_W-1:HALF_W]};
          lowHalfQ <= srcWord[HALF_W-1:0];
        end
      end
    end
  end

  assign txData   = txDataQ;
  assign baseWord = baseWordQ;
endmodule

// File: rtl/rdrsp_ctrl.sv
module rdrsp_ctrl
  import rdrsp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             txReady,
  input  logic             hdrOk,
  input  logic [CNT_W-1:0] decWords,
  input  logic [AW-1:0]    reqBase,
  input  logic [AW-1:0]    baseWord,
  output logic             reqReady,
  output logic             reqErr,
  output logic             memRdEn,
  output logic [AW-1:0]    memRdAddr,
  output logic             txValid,
  output logic             txSop,
  output logic             txEop,
  output logic [3:0]       txEmpty,
  output logic [7:0]       txSize,
  output dpCtrl_t          ctrl
);
  typedef enum logic [1:0] {S_IDLE, S_PRIME, S_SEND} state_t;
  state_t            stateQ;
  logic [CNT_W-1:0]  rdIdxQ;
  logic [CNT_W-1:0]  beatIdxQ;
  logic [CNT_W-1:0]  nWordsQ;
  logic              rdPendQ;
  logic              errQ;
  logic              fire;
  logic              lastBeat;

  always_comb begin
    ctrl      = '0;
    memRdEn   = 1'b0;
    memRdAddr = baseWord + AW'(rdIdxQ);
    reqReady  = (stateQ == S_IDLE);
    txValid   = (stateQ == S_SEND);
    fire      = txValid && txReady;
    lastBeat  = (beatIdxQ == nWordsQ);
    case (stateQ)
      S_IDLE: begin
        if (reqValid && hdrOk) begin
          ctrl.loadHdr = 1'b1;
          memRdEn      = 1'b1;
          memRdAddr    = reqBase;
        end
      end
      S_PRIME: begin
        ctrl.loadFirst = 1'b1;
        memRdEn        = 1'b1;
      end
      default: begin
        ctrl.useMem  = rdPendQ;
        ctrl.capNext = rdPendQ && !fire;
        if (fire && !lastBeat) begin
          ctrl.advance = 1'b1;
          ctrl.padTail = (beatIdxQ + CNT_W'(1)) == nWordsQ;
        end
        memRdEn = fire && (rdIdxQ < nWordsQ);
      end
    endcase
    txSop   = txValid && (beatIdxQ == '0);
    txEop   = txValid && lastBeat;
    txEmpty = txEop ? TAIL_EMPTY : 4'd0;
    txSize  = txValid ? (8'({nWordsQ, 4'b0000}) + RSP_HDR_BYTES) : 8'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      rdIdxQ   <= '0;
      beatIdxQ <= '0;
      nWordsQ  <= CNT_W'(2);
      rdPendQ  <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      errQ    <= 1'b0;
      rdPendQ <= 1'b0;
      case (stateQ)
        S_IDLE: begin
          if (reqValid && hdrOk) begin
            nWordsQ <= decWords;
            rdIdxQ  <= CNT_W'(1);
            stateQ  <= S_PRIME;
          end else if (reqValid) begin
            errQ <= 1'b1;
          end
        end
        S_PRIME: begin
          rdIdxQ   <= CNT_W'(2);
          rdPendQ  <= 1'b1;
          beatIdxQ <= '0;
          stateQ   <= S_SEND;
        end
        default: begin
          rdPendQ <= memRdEn;
          if (memRdEn) rdIdxQ <= rdIdxQ + CNT_W'(1);
          if (fire) begin
            if (lastBeat) stateQ <= S_IDLE;
            else beatIdxQ <= beatIdxQ + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign reqErr = errQ;
endmodule

// File: rtl/rdResponder.sv
module rdResponder
  import rdrsp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [HDR_W-1:0] reqHdr,
  output logic             reqErr,
  output logic             memRdEn,
  output logic [AW-1:0]    memRdAddr,
  input  logic [BUS_W-1:0] memRdData,
  output logic             txValid,
  input  logic             txReady,
  output logic [BUS_W-1:0] txData,
  output logic             txSop,
  output logic             txEop,
  output logic [3:0]       txEmpty,
  output logic [7:0]       txSize
);
  dpCtrl_t          ctrl;
  logic             hdrOk;
  logic [CNT_W-1:0] decWords;
  logic [AW-1:0]    reqBase;
  logic [AW-1:0]    baseWord;

  rdrsp_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .txReady(txReady),
    .hdrOk(hdrOk), .decWords(decWords), .reqBase(reqBase), .baseWord(baseWord),
    .reqReady(reqReady), .reqErr(reqErr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .txValid(txValid), .txSop(txSop), .txEop(txEop), .txEmpty(txEmpty),
    .txSize(txSize), .ctrl(ctrl)
  );

  rdrsp_datapath #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .reqHdr(reqHdr), .memRdData(memRdData), .ctrl(ctrl),
    .hdrOk(hdrOk), .decWords(decWords), .reqBase(reqBase), .baseWord(baseWord),
    .txData(txData)
  );
endmodule

// File: rtl/rdResponder_chk.sv
module rdResponder_chk (
  input logic         clk,
  input logic         rstN,
  input logic         reqReady,
  input logic         reqErr,
  input logic         txValid,
  input logic         txReady,
  input logic [127:0] txData,
  input logic         txSop,
  input logic         txEop,
  input logic [3:0]   txEmpty,
  input logic [7:0]   txSize
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txSop) &&
                            $stable(txEop) && $stable(txEmpty) && $stable(txSize));
  // R1
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && !txEop |=> txValid);
  // R2
  sop_eop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !(txSop && txEop));
  // R4
  empty_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txEop |-> txEmpty == 4'd0);
  // R3
  size_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && !txEop |=> $stable(txSize));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !reqReady);
  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && txEop |=> reqReady);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> !txValid && reqReady);
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |=> !reqErr);
endmodule

bind rdResponder rdResponder_chk u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .reqErr(reqErr),
  .txValid(txValid), .txReady(txReady), .txData(txData), .txSop(txSop),
  .txEop(txEop), .txEmpty(txEmpty), .txSize(txSize)
);

// File: tb/test_rdResponder.sv
module test_rdResponder;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [127:0] d;
    bit           sop;
    bit           eop;
    logic [3:0]   emp;
    logic [7:0]   sz;
  } beat_t;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           reqValid = 1'b0;
  logic           reqReady;
  logic [103:0]   reqHdr = '0;
  logic           reqErr;
  logic           memRdEn;
  logic [AW-1:0]  memRdAddr;
  logic [127:0]   memRdData = '0;
  logic           txValid;
  logic           txReady = 1'b1;
  logic [127:0]   txData;
  logic           txSop;
  logic           txEop;
  logic [3:0]     txEmpty;
  logic [7:0]     txSize;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  readyMode = 0;
  bit  running = 1'b0;
  bit  inPkt = 1'b0;
  bit  expErr = 1'b0;
  beat_t expQ[$];

  always #2 clk = ~clk;

  rdResponder #(.AW(AW)) i_rdResponder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqHdr(reqHdr), .reqErr(reqErr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .txValid(txValid), .txReady(txReady), .txData(txData),
    .txSop(txSop), .txEop(txEop), .txEmpty(txEmpty), .txSize(txSize)
  );

  function automatic logic [127:0] memWord(input int idx);
    logic [127:0] w;
    for (int b = 0; b < 16; b++) w[127 - 8*b -: 8] = 8'(idx * 7 + b * 13 + 8'h5A);
    return w;
  endfunction

  always_ff @(posedge clk) if (memRdEn) memRdData <= memWord(int'(memRdAddr));

  function automatic logic [103:0] mkHdr(input logic [1:0] pr, input logic [1:0] tt,
      input logic [3:0] ft, input logic [15:0] dst, input logic [15:0] src,
      input logic [3:0] tty, input logic [3:0] sz, input logic [7:0] tid,
      input logic [28:0] dw, input logic wp, input logic [1:0] xam, input logic [15:0] rsv);
    return {pr, tt, ft, dst, src, tty, sz, tid, dw, wp, xam, rsv};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected response built from requirement text only
  task automatic expectResponse(input logic [103:0] h);
    byte unsigned bytes[$];
    logic [63:0] rh;
    logic [1:0]  pr;
    int nW, base, nBeats;
    pr = (h[103:102] == 2'd3) ? 2'd3 : h[103:102] + 2'd1;
    rh = {pr, h[101:100], 4'd13, h[79:64], h[95:80], 4'd8, 4'd0, h[55:48], 8'h00};
    nW = h[18] ? 4 : 2;
    base = int'({h[17:16], h[47:19]} >> 1) % DEPTH;
    for (int b = 0; b < 8; b++) bytes.push_back(rh[63 - 8*b -: 8]);
    for (int w = 0; w < nW; w++) begin
      logic [127:0] mw;
      mw = memWord((base + w) % DEPTH);
      for (int b = 0; b < 16; b++) bytes.push_back(mw[127 - 8*b -: 8]);
    end
    nBeats = (bytes.size() + 15) / 16;
    for (int j = 0; j < nBeats; j++) begin
      beat_t bt;
      bt.d = '0;
      for (int b = 0; b < 16; b++)
        if (16*j + b < bytes.size()) bt.d[127 - 8*b -: 8] = bytes[16*j + b];
      bt.sop = (j == 0);
      bt.eop = (j == nBeats - 1);
      bt.emp = bt.eop ? 4'(nBeats * 16 - bytes.size()) : 4'd0;
      bt.sz  = 8'(bytes.size());
      expQ.push_back(bt);
    end
  endtask

  function automatic bit reqGood(input logic [103:0] h);
    return h[99:96] == 4'd2 && h[63:60] == 4'd4 && h[59:56] == 4'b1100 && h[15:0] == 16'h0;
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    if (running) begin
      cyc++;
      chk(reqErr == expErr, "R7 reqErr", 128'(reqErr), 128'(expErr));
      expErr = 1'b0;
      chk(reqReady == (expQ.size() == 0), "R10 reqReady", 128'(reqReady),
          128'(expQ.size() == 0));
      if (txValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R7 unexpected beat", txData, '0);
        end else begin
          chk(txData == expQ[0].d, "R8/R9 txData", txData, expQ[0].d);
          chk(txSop == expQ[0].sop, "R2 txSop", 128'(txSop), 128'(expQ[0].sop));
          chk(txEop == expQ[0].eop, "R2 txEop", 128'(txEop), 128'(expQ[0].eop));
          chk(txEmpty == expQ[0].emp, "R4 txEmpty", 128'(txEmpty), 128'(expQ[0].emp));
          chk(txSize == expQ[0].sz, "R3 txSize", 128'(txSize), 128'(expQ[0].sz));
          if (txReady) begin
            inPkt = !expQ[0].eop;
            void'(expQ.pop_front());
          end else begin
            inPkt = 1'b1;
          end
        end
      end else if (inPkt) begin
        chk(1'b0, "R1 valid dropped mid-packet", 128'(txValid), 128'(1));
      end
      if (reqValid && reqReady) begin
        if (reqGood(reqHdr)) expectResponse(reqHdr);
        else expErr = 1'b1;
      end
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", 128'(cyc), 128'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (readyMode == 0) txReady <= 1'b1;
    else txReady <= ($urandom_range(0, 99) < 55);
  end

  task automatic sendReq(input logic [103:0] h);
    bit wasReady;
    @(posedge clk); #1;
    reqHdr   = h;
    reqValid = 1'b1;
    do begin
      wasReady = reqReady;
      @(posedge clk); #1;
    end while (!wasReady);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(posedge clk); while (expQ.size() != 0 || !reqReady);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R11 reset state
    chk(txValid == 1'b0, "R11 txValid", 128'(txValid), 128'(0));
    chk(reqReady == 1'b1, "R11 reqReady", 128'(reqReady), 128'(1));
    chk(reqErr == 1'b0, "R11 reqErr", 128'(reqErr), 128'(0));
    rstN = 1'b1;
    running = 1'b1;

    // R3 R4 R6 R8 R9: 32-byte read, 40-byte packet in 3 beats
    sendReq(mkHdr(2'b01, 2'b01, 4'd2, 16'hDDDD, 16'hAAAA, 4'd4, 4'b1100, 8'hBB,
                  {28'h7654321, 1'b0}, 1'b0, 2'b00, 16'h0));
    waitIdle();
    // R6: 64-byte read, 72-byte packet, priority saturation (R8)
    sendReq(mkHdr(2'b11, 2'b01, 4'd2, 16'h1234, 16'h5678, 4'd4, 4'b1100, 8'h42,
                  29'h0000_01F6, 1'b1, 2'b10, 16'h0));
    waitIdle();
    // R5 R7: bad format type, bad transaction type, reserved bits set
    sendReq(mkHdr(2'b00, 2'b01, 4'd5, 16'h1, 16'h2, 4'd4, 4'b1100, 8'h01, 29'h10, 1'b0, 2'b00, 16'h0));
    waitIdle();
    sendReq(mkHdr(2'b00, 2'b01, 4'd2, 16'h1, 16'h2, 4'd5, 4'b1100, 8'h02, 29'h10, 1'b0, 2'b00, 16'h0));
    waitIdle();
    sendReq(mkHdr(2'b00, 2'b01, 4'd2, 16'h1, 16'h2, 4'd4, 4'b1100, 8'h03, 29'h10, 1'b0, 2'b00, 16'h0100));
    waitIdle();
    // R6 R7: unsupported size codes with either word pointer
    sendReq(mkHdr(2'b00, 2'b01, 4'd2, 16'h1, 16'h2, 4'd4, 4'b1011, 8'h04, 29'h10, 1'b0, 2'b00, 16'h0));
    sendReq(mkHdr(2'b00, 2'b01, 4'd2, 16'h1, 16'h2, 4'd4, 4'b1101, 8'h05, 29'h10, 1'b1, 2'b00, 16'h0));
    // valid request directly after an error
    sendReq(mkHdr(2'b10, 2'b00, 4'd2, 16'hBEEF, 16'hCAFE, 4'd4, 4'b1100, 8'h06, 29'h1FFFFFFE, 1'b1, 2'b11, 16'h0));
    waitIdle();

    // R1 R10: random backpressure, requests held while busy
    readyMode = 1;
    for (int n = 0; n < 60; n++) begin
      logic [103:0] h;
      h = mkHdr(2'($urandom), 2'($urandom), 4'd2, 16'($urandom), 16'($urandom), 4'd4,
                4'b1100, 8'(n), 29'($urandom), 1'($urandom), 2'($urandom), 16'h0);
      if (n % 9 == 4) h[99:96] = 4'd3;
      sendReq(h);
    end
    waitIdle();
    readyMode = 0;
    waitIdle();
    chk(expQ.size() == 0, "R1 all beats delivered", 128'(expQ.size()), 128'(0));
    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule